// File: doc/BRIEF.md
# Video Sync Flywheel Generator

This block produces the horizontal sync, vertical sync, field, active-video and data-valid flags that accompany a video decoder's pixel output. A pixel counter and a line counter are normally pulled into step by the horizontal and vertical sync strobes that the front end detects. When those strobes stop, the counters keep running on their own. The pixel counter wrap then sets the line rate, and the line counter wrap sets the frame rate. Downstream logic therefore sees steady timing through dropouts.

Horizontal sync and the active window are set by programmable pixel positions. Vertical sync covers the first lines after each frame start. The field flag comes from where in the line a vertical strobe arrives. If no vertical strobe is seen for a fixed number of lines, the field flag flips by itself. After a hardware or software reset, all five output enables stay low until the counters have produced their first line start. A burst mode holds the active flag high at all times.

Top module: `sync_flywheel`

## Requirements
- R1: With no horizontal strobe, the pixel counter runs from 0 to `line_len` and wraps, so rising edges of `hsync` are `line_len`+1 cycles apart.
- R2: A high `hs_det` sampled at a clock edge reloads the pixel counter to 0 and counts as a line start. Periodic strobes shorter than the line length therefore set the `hsync` period.
- R3: `hsync` is high, one cycle after the counter value, for every pixel count p with `hs_start` <= p < `hs_end`. Each pulse lasts `hs_end`-`hs_start` cycles.
- R4: A high `vs_det` clears the line counter and loads `field`. The field becomes 0 (odd) if the pixel count at that edge is at most `line_len`/2 (integer division), and 1 (even) otherwise.
- R5: When 337 line starts pass with no `vs_det`, the line counter wraps to 0 and `field` inverts. This happens on the edge of the 337th line start.
- R6: If `vs_det` falls on the same edge as the 337-line wrap, the vertical strobe wins. `field` takes the position-based value rather than toggling, and the 337-line count restarts from that edge.
- R7: `vsync` is high while the line counter is below 3. It rises one cycle after the line counter is cleared and falls one cycle after the third line start that follows.
- R8: `active` is high when the pixel count lies in [`act_start`, `act_end`), one cycle late. It is high on every cycle while `burst_mode` is high.
- R9: `dvld` follows the same window as `active` (or `burst_mode`), but is held low while `vsync` timing is in its vertical blank (line counter below 3).
- R10: Asynchronous `rst_n` low or a sampled `soft_rst` clears `out_oe`, `field` and both counters. All five `out_oe` bits return high one cycle after the first line start, which is `line_len`+1 edges after reset with no strobes. `out_oe` bit order: bit 0 hsync, 1 vsync, 2 field, 3 active, 4 dvld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous software reset, active high |
| hs_det | input | 1 | Detected horizontal sync strobe |
| vs_det | input | 1 | Detected vertical sync strobe |
| burst_mode | input | 1 | Burst output mode, forces active high |
| line_len | input | PIX_W | Last pixel index of a free-running line |
| hs_start | input | PIX_W | First pixel count with hsync high |
| hs_end | input | PIX_W | First pixel count with hsync low again |
| act_start | input | PIX_W | First pixel count of the active window |
| act_end | input | PIX_W | First pixel count past the active window |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| field | output | 1 | Field flag, 0 odd, 1 even |
| active | output | 1 | Active-video flag |
| dvld | output | 1 | Data valid |
| out_oe | output | 5 | Output enables for hsync, vsync, field, active, dvld |

## Verification
A vertical strobe and the 337-line flywheel timeout can land on the same clock edge. Both would update the field flag and the line counter. The bench locks the line phase with one horizontal strobe and sets the field to even with a late vertical strobe. It then counts out exactly 336 free-running lines plus the wrap cycle, and fires a second late vertical strobe on the edge of the 337th line start. It judges the result in two ways. `field` must stay even instead of toggling, and the next automatic toggle must come a full 337 lines after that edge, not after the earlier one.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
  // Output enable bit positions on out_oe.
  localparam int OE_HSYNC  = 0;
  localparam int OE_VSYNC  = 1;
  localparam int OE_FIELD  = 2;
  localparam int OE_ACTIVE = 3;
  localparam int OE_DVLD   = 4;
  localparam int OE_BITS   = 5;

  typedef struct packed {
    logic hsync;
    logic vsync;
    logic active;
    logic dvld;
  } sfw_flags_t;
endpackage

// File: rtl/sfw_pixel_ctr.sv
module sfw_pixel_ctr #(
  parameter int PIX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             hs_det,
  input  logic [PIX_W-1:0] line_len,
  output logic [PIX_W-1:0] pix,
  output logic             line_wrap
);
  logic [PIX_W-1:0] pix_q, pix_d;
  logic             end_of_line;

  always_comb begin
    end_of_line = (pix_q == line_len);
    line_wrap   = !soft_rst && (hs_det || end_of_line);
    if (soft_rst || hs_det || end_of_line)
      pix_d = '0;
    else
      pix_d = pix_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_q <= '0;
    else        pix_q <= pix_d;
  end

  assign pix = pix_q;
endmodule

// File: rtl/sfw_line_ctr.sv
module sfw_line_ctr #(
  parameter int PIX_W         = 10,
  parameter int TIMEOUT_LINES = 337,
  parameter int VS_LINES      = 3,
  localparam int LINE_W       = $clog2(TIMEOUT_LINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              vs_det,
  input  logic              line_wrap,
  input  logic [PIX_W-1:0]  pix,
  input  logic [PIX_W-1:0]  line_len,
  output logic [LINE_W-1:0] ln,
  output logic              field,
  output logic              vblank
);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(TIMEOUT_LINES - 1);
  localparam logic [LINE_W-1:0] VS_LIM    = LINE_W'(VS_LINES);

  logic [LINE_W-1:0] ln_q, ln_d;
  logic              field_q, field_d;
  logic              late_half, timeout;

  always_comb begin
    late_half = (pix > (line_len >> 1));
    timeout   = line_wrap && (ln_q == LAST_LINE);
    ln_d      = ln_q;
    field_d   = field_q;
    if (soft_rst) begin
      ln_d    = '0;
      field_d = 1'b0;
    end else if (vs_det) begin
      ln_d    = '0;
      field_d = late_half;
    end else if (line_wrap) begin
      ln_d    = timeout ? '0 : ln_q + 1'b1;
      field_d = timeout ? ~field_q : field_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ln_q    <= '0;
      field_q <= 1'b0;
    end else begin
      ln_q    <= ln_d;
      field_q <= field_d;
    end
  end

  assign ln     = ln_q;
  assign field  = field_q;
  assign vblank = (ln_q < VS_LIM);
endmodule

// File: rtl/sfw_out_stage.sv
module sfw_out_stage
  import sfw_pkg::*;
#(
  parameter int PIX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             burst_mode,
  input  logic             line_wrap,
  input  logic             vblank,
  input  logic [PIX_W-1:0] pix,
  input  logic [PIX_W-1:0] hs_start,
  input  logic [PIX_W-1:0] hs_end,
  input  logic [PIX_W-1:0] act_start,
  input  logic [PIX_W-1:0] act_end,
  output sfw_flags_t       flags,
  output logic             oe
);
  sfw_flags_t flags_q, flags_d;
  logic       oe_q, oe_d;
  logic       hs_win, act_win, act_any;

  always_comb begin
    hs_win  = (pix >= hs_start) && (pix < hs_end);
    act_win = (pix >= act_start) && (pix < act_end);
    act_any = burst_mode || act_win;
    if (soft_rst) begin
      flags_d = '0;
    end else begin
      flags_d.hsync  = hs_win;
      flags_d.vsync  = vblank;
      flags_d.active = act_any;
      flags_d.dvld   = act_any && !vblank;
    end
    if (soft_rst)       oe_d = 1'b0;
    else if (line_wrap) oe_d = 1'b1;
    else                oe_d = oe_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      flags_q <= flags_d;
      oe_q    <= oe_d;
    end
  end

  assign flags = flags_q;
  assign oe    = oe_q;
endmodule

// File: rtl/sync_flywheel.sv
module sync_flywheel
  import sfw_pkg::*;
#(
  parameter int PIX_W         = 10,
  parameter int TIMEOUT_LINES = 337,
  parameter int VS_LINES      = 3,
  localparam int LINE_W       = $clog2(TIMEOUT_LINES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               hs_det,
  input  logic               vs_det,
  input  logic               burst_mode,
  input  logic [PIX_W-1:0]   line_len,
  input  logic [PIX_W-1:0]   hs_start,
  input  logic [PIX_W-1:0]   hs_end,
  input  logic [PIX_W-1:0]   act_start,
  input  logic [PIX_W-1:0]   act_end,
  output logic               hsync,
  output logic               vsync,
  output logic               field,
  output logic               active,
  output logic               dvld,
  output logic [OE_BITS-1:0] out_oe
);
  logic [PIX_W-1:0]  pix_cnt;
  logic [LINE_W-1:0] ln_cnt;
  logic              line_wrap;
  logic              vblank;
  logic              oe_all;
  sfw_flags_t        flags;

  sfw_pixel_ctr #(.PIX_W(PIX_W)) u_pix (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .hs_det    (hs_det),
    .line_len  (line_len),
    .pix       (pix_cnt),
    .line_wrap (line_wrap)
  );

  sfw_line_ctr #(
    .PIX_W         (PIX_W),
    .TIMEOUT_LINES (TIMEOUT_LINES),
    .VS_LINES      (VS_LINES)
  ) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .vs_det    (vs_det),
    .line_wrap (line_wrap),
    .pix       (pix_cnt),
    .line_len  (line_len),
    .ln        (ln_cnt),
    .field     (field),
    .vblank    (vblank)
  );

  sfw_out_stage #(.PIX_W(PIX_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .burst_mode (burst_mode),
    .line_wrap  (line_wrap),
    .vblank     (vblank),
    .pix        (pix_cnt),
    .hs_start   (hs_start),
    .hs_end     (hs_end),
    .act_start  (act_start),
    .act_end    (act_end),
    .flags      (flags),
    .oe         (oe_all)
  );

  assign hsync  = flags.hsync;
  assign vsync  = flags.vsync;
  assign active = flags.active;
  assign dvld   = flags.dvld;

  generate
    for (genvar g = 0; g < OE_BITS; g++) begin : g_oe
      assign out_oe[g] = oe_all;
    end
  endgenerate
endmodule

// File: rtl/sfw_checker.sv
module sfw_checker #(
  parameter int PIX_W  = 10,
  parameter int LINE_W = 9,
  parameter int OE_N   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              vs_det,
  input logic              burst_mode,
  input logic              line_wrap,
  input logic [LINE_W-1:0] ln_cnt,
  input logic [PIX_W-1:0]  pix_cnt,
  input logic [PIX_W-1:0]  hs_start,
  input logic              hsync,
  input logic              vsync,
  input logic              field,
  input logic              active,
  input logic [OE_N-1:0]   out_oe
);
  a_r10_soft_clears_oe: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (out_oe == '0));

  a_r10_oe_rises_on_line: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_oe[0]) |-> $past(line_wrap));

  a_r8_burst_active: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_mode && !soft_rst) |=> active);

  a_r6_vs_clears_line: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_det && !soft_rst) |=> (ln_cnt == '0));

  a_r5_field_change_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field) |-> ($past(vs_det) || $past(soft_rst) || $past(line_wrap)));

  a_r3_hsync_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync) |-> ($past(pix_cnt) == hs_start));

  a_r7_vsync_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> ($past(ln_cnt) == '0));
endmodule

bind sync_flywheel sfw_checker #(
  .PIX_W  (PIX_W),
  .LINE_W (LINE_W),
  .OE_N   (sfw_pkg::OE_BITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst   (soft_rst),
  .vs_det     (vs_det),
  .burst_mode (burst_mode),
  .line_wrap  (line_wrap),
  .ln_cnt     (ln_cnt),
  .pix_cnt    (pix_cnt),
  .hs_start   (hs_start),
  .hsync      (hsync),
  .vsync      (vsync),
  .field      (field),
  .active     (active),
  .out_oe     (out_oe)
);

// File: tb/sim_sync_flywheel.sv
`timescale 1ns/1ps
module sim_sync_flywheel;
  localparam int PW = 10;
  localparam real TCLK = 20.0;

  logic          clk;
  logic          rst_n, soft_rst, hs_det, vs_det, burst_mode;
  logic [PW-1:0] line_len, hs_start, hs_end, act_start, act_end;
  logic          hsync, vsync, field, active, dvld;
  logic [4:0]    out_oe;

  int checks = 0;
  int errors = 0;

  sync_flywheel u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .hs_det(hs_det),
    .vs_det(vs_det), .burst_mode(burst_mode), .line_len(line_len),
    .hs_start(hs_start), .hs_end(hs_end), .act_start(act_start),
    .act_end(act_end), .hsync(hsync), .vsync(vsync), .field(field),
    .active(active), .dvld(dvld), .out_oe(out_oe)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Lock line phase: after return, pixel count is 0 (edge E0 just passed).
  task automatic sync_line();
    hs_det = 1'b1;
    step(1);
    hs_det = 1'b0;
  endtask

  // Fire vs_det so it is sampled k edges after the current point.
  task automatic pulse_vs(int k);
    step(k - 1);
    vs_det = 1'b1;
    step(1);
    vs_det = 1'b0;
  endtask

  task automatic run_hs(int period, int ncyc, output int gap, output int width);
    int last_rise;
    int cnt;
    logic prev;
    last_rise = -1; cnt = 0; gap = 0; width = 0; prev = hsync;
    for (int i = 0; i < ncyc; i++) begin
      hs_det = (period != 0) && (i % period == 0);
      step(1);
      if (hsync && !prev) begin
        if (last_rise >= 0) gap = i - last_rise;
        last_rise = i;
        cnt = 0;
      end
      if (hsync) cnt++;
      if (!hsync && prev) width = cnt;
      prev = hsync;
    end
    hs_det = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(3);
    check("R10 oe in reset", out_oe, 0);
    check("R10 field in reset", field, 0);
    rst_n = 1'b1;
    step(15);
    check("R10 oe before first line", out_oe, 0);
    step(1);
    check("R10 oe after first line", out_oe, 31);
  endtask

  task automatic t_free_hsync();
    int gap, width;
    run_hs(0, 80, gap, width);
    check("R1 free-run hsync period", gap, 16);
    check("R3 hsync width", width, 3);
  endtask

  task automatic t_locked_hsync();
    int gap, width;
    run_hs(12, 96, gap, width);
    check("R2 strobe hsync period", gap, 12);
    check("R3 hsync width locked", width, 3);
  endtask

  task automatic t_field_pos();
    sync_line(); pulse_vs(3);
    check("R4 early vs odd", field, 0);
    sync_line(); pulse_vs(9);
    check("R4 just past half even", field, 1);
    sync_line(); pulse_vs(8);
    check("R4 at half odd", field, 0);
    sync_line(); pulse_vs(13);
    check("R4 late vs even", field, 1);
  endtask

  task automatic t_vsync_dvld();
    int dv, ac;
    sync_line(); pulse_vs(3);
    step(1);
    check("R7 vsync rises", vsync, 1);
    dv = 0;
    for (int i = 0; i < 44; i++) begin
      step(1);
      if (dvld) dv++;
    end
    check("R7 vsync held", vsync, 1);
    check("R9 dvld low in blank", dv, 0);
    step(1);
    check("R7 vsync falls", vsync, 0);
    dv = 0; ac = 0;
    for (int i = 0; i < 16; i++) begin
      step(1);
      if (dvld) dv++;
      if (active) ac++;
    end
    check("R9 dvld per line", dv, 8);
    check("R8 active per line", ac, 8);
  endtask

  task automatic t_burst();
    int ac;
    burst_mode = 1'b1;
    step(1);
    ac = 0;
    for (int i = 0; i < 32; i++) begin
      step(1);
      if (active) ac++;
    end
    check("R8 burst active always", ac, 32);
    burst_mode = 1'b0;
    step(2);
  endtask

  task automatic t_timeout();
    sync_line(); pulse_vs(13);
    check("R5 start even", field, 1);
    step(5378);
    check("R5 before 337th line", field, 1);
    step(1);
    check("R5 toggle at 337 lines", field, 0);
    step(5391);
    check("R5 before second timeout", field, 0);
    step(1);
    check("R5 second toggle", field, 1);
  endtask

  task automatic t_coincide();
    sync_line(); pulse_vs(13);
    step(5378);
    vs_det = 1'b1;
    step(1);
    vs_det = 1'b0;
    check("R6 vs wins over timeout", field, 1);
    step(5391);
    check("R6 count restarted", field, 1);
    step(1);
    check("R6 toggle after restart", field, 0);
  endtask

  task automatic t_soft();
    sync_line(); pulse_vs(13);
    soft_rst = 1'b1;
    step(1);
    soft_rst = 1'b0;
    check("R10 soft oe low", out_oe, 0);
    check("R10 soft field cleared", field, 0);
    step(15);
    check("R10 soft oe before line", out_oe, 0);
    step(1);
    check("R10 soft oe restored", out_oe, 31);
  endtask

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; hs_det = 1'b0; vs_det = 1'b0;
    burst_mode = 1'b0;
    line_len = 10'd15; hs_start = 10'd1; hs_end = 10'd4;
    act_start = 10'd5; act_end = 10'd13;
    t_reset();
    t_free_hsync();
    t_locked_hsync();
    t_field_pos();
    t_vsync_dvld();
    t_burst();
    t_timeout();
    t_coincide();
    t_soft();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(TCLK * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule